// File: doc/BRIEF.md
# Sticky Interrupt Flag Pulse Generator

This block gathers the interrupt sources of a two-channel audio converter front end and turns them into software-visible flags and a timed interrupt output. There are five sources: a left and a right "signal below noise floor" indication, a standard and an auxiliary interrupt line from a signal-processing engine, and a data-ready event. Each source is edge-detected into a sticky flag that clears when software reads it. A separate status register shows the raw source levels at the moment of the read and does not latch them.

A control register chooses which source groups may raise the interrupt output. Each rising edge of the OR of the enabled sources starts one active-high pulse of `PULSE_CYC` clock cycles. Repeat mode is the alternative. In that mode the pulse recurs every `PERIOD_CYC` cycles until software reads one of the two sticky flag registers. Pulse width and period are counted in clock cycles. Their defaults are derived from the clock rate and give nominal 2 ms and 4 ms.

Software reaches the block through a simple synchronous port. A read strobe returns the addressed register one cycle later. The same clock edge applies the clear and the stop that the read causes.

Top module: `irq_pulse_flags`

## Requirements
- R1: After reset every register reads 0x00 and `irq` is low.
- R2: A rising edge of a source sets its sticky flag. The flag register at address 0 holds the left noise flag in bit 6, the right noise flag in bit 5, the engine standard interrupt in bit 4 and the engine auxiliary interrupt in bit 3, with bits 7 and 2..0 reading 0. The data-ready flag sits in bit 0 of address 3, and bits 7..1 of that address read 0.
- R3: A read of address 0 or 3 returns the flags and then clears them. A source that stays high does not set its flag again after the clear; only a fresh rising edge sets it again.
- R4: If a source rises in the same cycle as a clearing read, its flag is set after the read, and the read itself returns the earlier value.
- R5: Address 1 returns the instantaneous source levels in the layout of address 0. Reading it clears nothing.
- R6: Address 2 is the control register. Bit 4 enables the noise group, bit 2 the engine group, bit 1 data-ready, and bit 0 selects repeat mode. Bits 7..5 and 3 read 0. Writes to addresses 0, 1 and 3 have no effect.
- R7: A pulse starts only on a rising edge of the OR of the sources whose group is enabled. Edges of disabled sources never pulse `irq`.
- R8: In single mode, `irq` is high for exactly `PULSE_CYC` cycles, starting the cycle after the edge is sampled. An edge that arrives during the pulse neither extends nor restarts it.
- R9: In repeat mode, `irq` is high for `PULSE_CYC` cycles and low for `PERIOD_CYC - PULSE_CYC` cycles, again and again. A read of address 0 or 3 drives it low from the next cycle on, and it stays low until a new edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| noise_lo_l | input | 1 | Left channel power below noise threshold |
| noise_lo_r | input | 1 | Right channel power below noise threshold |
| eng_irq_std | input | 1 | Engine standard interrupt line |
| eng_irq_aux | input | 1 | Engine auxiliary interrupt line |
| data_rdy | input | 1 | Converter data-ready event |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Read data, valid the cycle after the strobe |
| irq | output | 1 | Active-high interrupt pulse output |

## Verification
Any source edge seen at clock edge k sets its flag and raises `irq` at edge k, so both results show at the half-cycle after k. Read data and the clear or stop that a read triggers both take effect at the edge that samples the strobe, so the value belongs to the following half-cycle. The bench drives every input on the falling edge and samples on the next falling edge, which lands each check exactly one register stage after its stimulus. Pulse trains are compared sample by sample against a pattern computed from the width and period: high for `i mod PERIOD < PULSE`, counted from the first sample after the trigger.

// File: rtl/irq_pulse_flags_pkg.sv
package irq_pulse_flags_pkg;

   localparam int REG_W   = 8;
   localparam int ADDR_W  = 2;

   // source index order inside the internal source vector
   localparam int SRC_L    = 0;
   localparam int SRC_R    = 1;
   localparam int SRC_STD  = 2;
   localparam int SRC_AUX  = 3;
   localparam int SRC_DRDY = 4;
   localparam int N_SRC    = 5;

   typedef enum logic [ADDR_W-1:0] {
      SEL_ADC_FLAGS = 2'd0,
      SEL_LIVE      = 2'd1,
      SEL_CTRL      = 2'd2,
      SEL_DRDY_FLAG = 2'd3
   } reg_sel_e;

   // field positions seen by software
   localparam int POS_L    = 6;
   localparam int POS_R    = 5;
   localparam int POS_STD  = 4;
   localparam int POS_AUX  = 3;

   localparam int CTL_EN_NOISE = 4;
   localparam int CTL_EN_ENG   = 2;
   localparam int CTL_EN_DRDY  = 1;
   localparam int CTL_REPEAT   = 0;

   localparam logic [REG_W-1:0] CTRL_MASK =
      REG_W'((1 << CTL_EN_NOISE) | (1 << CTL_EN_ENG) | (1 << CTL_EN_DRDY) | (1 << CTL_REPEAT));

   // place four converter-side bits (L, R, STD, AUX) into a register byte
   function automatic logic [REG_W-1:0] pack_adc(input logic [3:0] f);
      logic [REG_W-1:0] v;
      v = '0;
      v[POS_L]   = f[SRC_L];
      v[POS_R]   = f[SRC_R];
      v[POS_STD] = f[SRC_STD];
      v[POS_AUX] = f[SRC_AUX];
      return v;
   endfunction

endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] src,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flag
);

   generate
      if (N < 1) begin : g_bad_n
         $error("irq_sticky_bank: N must be at least 1");
      end
   endgenerate

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic prev_q;
      logic flag_q;
      logic rise;

      assign rise = src[i] & ~prev_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            prev_q <= 1'b0;
            flag_q <= 1'b0;
         end else begin
            prev_q <= src[i];
            // a fresh edge wins over a clear in the same cycle
            flag_q <= rise | (flag_q & ~clr[i]);
         end
      end

      assign flag[i] = flag_q;
   end

endmodule

// File: rtl/irq_pulse_timer.sv
module irq_pulse_timer #(
   parameter int PULSE_CYC  = 4,
   parameter int PERIOD_CYC = 8,
   parameter bit REPEAT_EN  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   input  logic repeat_mode,
   input  logic stop,
   output logic pulse,
   output logic busy,
   output logic repeating
);

   localparam int CNT_W = $clog2(PERIOD_CYC + 1);
   localparam logic [CNT_W-1:0] PULSE_LAST  = CNT_W'(PULSE_CYC - 1);
   localparam logic [CNT_W-1:0] PERIOD_LAST = CNT_W'(PERIOD_CYC - 1);
   localparam logic [CNT_W-1:0] PULSE_LIM   = CNT_W'(PULSE_CYC);

   generate
      if (PULSE_CYC < 1 || PERIOD_CYC <= PULSE_CYC) begin : g_bad_timing
         $error("irq_pulse_timer: need 1 <= PULSE_CYC < PERIOD_CYC");
      end
   endgenerate

   logic             trig_q;
   logic             active_q;
   logic             rep_q;
   logic [CNT_W-1:0] cnt_q;
   logic             event_hit;
   logic             rep_sel;

   generate
      if (REPEAT_EN) begin : g_rep
         assign rep_sel = repeat_mode;
      end else begin : g_norep
         assign rep_sel = 1'b0;
      end
   endgenerate

   assign event_hit = trig & ~trig_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trig_q   <= 1'b0;
         active_q <= 1'b0;
         rep_q    <= 1'b0;
         cnt_q    <= '0;
      end else begin
         trig_q <= trig;
         if (!active_q) begin
            if (event_hit) begin
               active_q <= 1'b1;
               rep_q    <= rep_sel;
               cnt_q    <= '0;
            end
         end else if (rep_q) begin
            if (stop) begin
               active_q <= 1'b0;
               rep_q    <= 1'b0;
               cnt_q    <= '0;
            end else begin
               cnt_q <= (cnt_q == PERIOD_LAST) ? '0 : cnt_q + 1'b1;
            end
         end else if (cnt_q == PULSE_LAST) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign pulse     = active_q & (cnt_q < PULSE_LIM);
   assign busy      = active_q;
   assign repeating = active_q & rep_q;

endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
   import irq_pulse_flags_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [REG_W-1:0]  wdata,
   input  logic              rd,
   input  logic [3:0]        adc_flag,
   input  logic [3:0]        adc_live,
   input  logic              drdy_flag,
   output logic [REG_W-1:0]  rdata,
   output logic [REG_W-1:0]  ctrl,
   output logic              clr_adc,
   output logic              clr_drdy
);

   reg_sel_e         sel;
   logic [REG_W-1:0] ctrl_q;
   logic [REG_W-1:0] rdata_q;
   logic [REG_W-1:0] rmux;

   assign sel = reg_sel_e'(addr);

   always_comb begin
      unique case (sel)
         SEL_ADC_FLAGS: rmux = pack_adc(adc_flag);
         SEL_LIVE:      rmux = pack_adc(adc_live);
         SEL_CTRL:      rmux = ctrl_q;
         SEL_DRDY_FLAG: rmux = {{(REG_W-1){1'b0}}, drdy_flag};
         default:       rmux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         rdata_q <= '0;
      end else begin
         if (wr && sel == SEL_CTRL) begin
            ctrl_q <= wdata & CTRL_MASK;
         end
         if (rd) begin
            rdata_q <= rmux;
         end
      end
   end

   assign clr_adc  = rd && (sel == SEL_ADC_FLAGS);
   assign clr_drdy = rd && (sel == SEL_DRDY_FLAG);
   assign rdata    = rdata_q;
   assign ctrl     = ctrl_q;

endmodule

// File: rtl/irq_pulse_flags.sv
module irq_pulse_flags
   import irq_pulse_flags_pkg::*;
#(
   parameter int CLK_KHZ    = 250000,
   parameter int PULSE_CYC  = 2 * CLK_KHZ,
   parameter int PERIOD_CYC = 4 * CLK_KHZ,
   parameter bit REPEAT_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              noise_lo_l,
   input  logic              noise_lo_r,
   input  logic              eng_irq_std,
   input  logic              eng_irq_aux,
   input  logic              data_rdy,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [REG_W-1:0]  reg_wdata,
   input  logic              reg_rd,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              irq
);

   generate
      if (CLK_KHZ < 1) begin : g_bad_clk
         $error("irq_pulse_flags: CLK_KHZ must be positive");
      end
   endgenerate

   logic [N_SRC-1:0] src_vec;
   logic [N_SRC-1:0] flag_vec;
   logic [N_SRC-1:0] clr_vec;
   logic [REG_W-1:0] ctrl;
   logic             clr_adc;
   logic             clr_drdy;
   logic             any_enabled;
   logic             tmr_busy;
   logic             tmr_repeating;
   logic [2:0]       en_groups;

   assign src_vec[SRC_L]    = noise_lo_l;
   assign src_vec[SRC_R]    = noise_lo_r;
   assign src_vec[SRC_STD]  = eng_irq_std;
   assign src_vec[SRC_AUX]  = eng_irq_aux;
   assign src_vec[SRC_DRDY] = data_rdy;

   assign clr_vec = {clr_drdy, {4{clr_adc}}};

   irq_sticky_bank #(.N(N_SRC)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (src_vec),
      .clr   (clr_vec),
      .flag  (flag_vec)
   );

   irq_reg_port u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (reg_addr),
      .wr        (reg_wr),
      .wdata     (reg_wdata),
      .rd        (reg_rd),
      .adc_flag  (flag_vec[3:0]),
      .adc_live  (src_vec[3:0]),
      .drdy_flag (flag_vec[SRC_DRDY]),
      .rdata     (reg_rdata),
      .ctrl      (ctrl),
      .clr_adc   (clr_adc),
      .clr_drdy  (clr_drdy)
   );

   assign en_groups = {ctrl[CTL_EN_NOISE], ctrl[CTL_EN_ENG], ctrl[CTL_EN_DRDY]};

   assign any_enabled =
        (ctrl[CTL_EN_NOISE] & (noise_lo_l  | noise_lo_r))
      | (ctrl[CTL_EN_ENG]   & (eng_irq_std | eng_irq_aux))
      | (ctrl[CTL_EN_DRDY]  &  data_rdy);

   irq_pulse_timer #(
      .PULSE_CYC  (PULSE_CYC),
      .PERIOD_CYC (PERIOD_CYC),
      .REPEAT_EN  (REPEAT_EN)
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .trig        (any_enabled),
      .repeat_mode (ctrl[CTL_REPEAT]),
      .stop        (clr_adc | clr_drdy),
      .pulse       (irq),
      .busy        (tmr_busy),
      .repeating   (tmr_repeating)
   );

endmodule

// File: rtl/irq_pulse_flags_chk.sv
module irq_pulse_flags_chk
   import irq_pulse_flags_pkg::*;
#(
   parameter int PULSE_CYC = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_rd,
   input logic [REG_W-1:0]  reg_rdata,
   input logic [3:0]        adc_src,
   input logic [3:0]        adc_flags,
   input logic [2:0]        en_groups,
   input logic              busy,
   input logic              repeating,
   input logic              irq
);

   localparam int RUN_W = $clog2(PULSE_CYC + 2);
   localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(PULSE_CYC + 1);

   logic [RUN_W-1:0] hi_run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_run <= '0;
      end else if (!irq) begin
         hi_run <= '0;
      end else if (hi_run != RUN_MAX) begin
         hi_run <= hi_run + 1'b1;
      end
   end

   AST_PULSE_NOT_LONGER: assert property (@(posedge clk) disable iff (!rst_n)
      hi_run <= RUN_W'(PULSE_CYC)); // R8

   AST_READ_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == SEL_ADC_FLAGS && adc_src == 4'b0) |=> (adc_flags == 4'b0)); // R3

   AST_CTRL_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == SEL_CTRL) |=> (reg_rdata[7:5] == 3'b0 && !reg_rdata[3])); // R6

   AST_DISABLED_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (en_groups == 3'b0 && !busy) |=> !irq); // R7

   AST_REPEAT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (repeating && reg_rd && (reg_addr == SEL_ADC_FLAGS || reg_addr == SEL_DRDY_FLAG)) |=> !irq); // R9

endmodule

bind irq_pulse_flags irq_pulse_flags_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_rd    (reg_rd),
   .reg_rdata (reg_rdata),
   .adc_src   (src_vec[3:0]),
   .adc_flags (flag_vec[3:0]),
   .en_groups (en_groups),
   .busy      (tmr_busy),
   .repeating (tmr_repeating),
   .irq       (irq)
);

// File: tb/irq_pulse_flags_test.sv
module irq_pulse_flags_test;

   localparam int PW = 4;
   localparam int PP = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       nl = 1'b0, nr = 1'b0, estd = 1'b0, eaux = 1'b0, drdy = 1'b0;
   logic [1:0] addr = 2'd0;
   logic       wr = 1'b0, rd = 1'b0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic       irq;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   irq_pulse_flags #(.PULSE_CYC(PW), .PERIOD_CYC(PP)) uut (
      .clk(clk), .rst_n(rst_n),
      .noise_lo_l(nl), .noise_lo_r(nr), .eng_irq_std(estd), .eng_irq_aux(eaux),
      .data_rdy(drdy),
      .reg_addr(addr), .reg_wr(wr), .reg_wdata(wdata), .reg_rd(rd),
      .reg_rdata(rdata), .irq(irq)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk); addr = a; rd = 1'b1;
      @(negedge clk); rd = 1'b0; d = rdata;
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic flush();
      logic [7:0] d;
      nl = 0; nr = 0; estd = 0; eaux = 0; drdy = 0;
      idle(PP + 2);
      rd_reg(2'd0, d);
      rd_reg(2'd3, d);
      idle(2);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      check("R1 irq", {7'd0, irq}, 8'h00);
      for (int a = 0; a < 4; a++) begin
         rd_reg(2'(a), d);
         check($sformatf("R1 reg%0d", a), d, 8'h00);
      end
   endtask

   task automatic t_flag_bits();
      logic [7:0] d;
      @(negedge clk); nl = 1; @(negedge clk); nl = 0;
      rd_reg(2'd0, d); check("R2 left bit6", d, 8'h40);
      @(negedge clk); nr = 1; @(negedge clk); nr = 0;
      rd_reg(2'd0, d); check("R2 right bit5", d, 8'h20);
      @(negedge clk); estd = 1; eaux = 1; @(negedge clk); estd = 0; eaux = 0;
      rd_reg(2'd0, d); check("R2 engine bits4,3", d, 8'h18);
      @(negedge clk); drdy = 1; @(negedge clk); drdy = 0;
      rd_reg(2'd3, d); check("R2 data-ready bit0", d, 8'h01);
      rd_reg(2'd3, d); check("R3 data-ready cleared", d, 8'h00);
   endtask

   task automatic t_clear_hold();
      logic [7:0] d;
      @(negedge clk); nl = 1;
      rd_reg(2'd0, d); check("R3 first read", d, 8'h40);
      rd_reg(2'd0, d); check("R3 held source no reset", d, 8'h00);
      @(negedge clk); nl = 0; @(negedge clk); nl = 1; @(negedge clk); nl = 0;
      rd_reg(2'd0, d); check("R3 fresh edge sets", d, 8'h40);
   endtask

   task automatic t_collision();
      logic [7:0] d;
      @(negedge clk); eaux = 1; @(negedge clk); eaux = 0;
      @(negedge clk); addr = 2'd0; rd = 1; estd = 1;
      @(negedge clk); rd = 0; d = rdata; estd = 0;
      check("R4 read returns old", d, 8'h08);
      rd_reg(2'd0, d); check("R4 new edge kept", d, 8'h10);
   endtask

   task automatic t_live();
      logic [7:0] d;
      @(negedge clk); estd = 1; nr = 1;
      rd_reg(2'd1, d); check("R5 live levels", d, 8'h30);
      rd_reg(2'd1, d); check("R5 live again", d, 8'h30);
      @(negedge clk); estd = 0; nr = 0;
      rd_reg(2'd1, d); check("R5 live low", d, 8'h00);
      rd_reg(2'd0, d); check("R5 live read kept sticky", d, 8'h30);
   endtask

   task automatic t_ctrl();
      logic [7:0] d;
      wr_reg(2'd2, 8'hFF);
      rd_reg(2'd2, d); check("R6 ctrl writable bits", d, 8'h17);
      wr_reg(2'd2, 8'h00);
      rd_reg(2'd2, d); check("R6 ctrl cleared", d, 8'h00);
      wr_reg(2'd0, 8'hFF); wr_reg(2'd1, 8'hFF); wr_reg(2'd3, 8'hFF);
      rd_reg(2'd0, d); check("R6 write addr0 ignored", d, 8'h00);
      rd_reg(2'd3, d); check("R6 write addr3 ignored", d, 8'h00);
      rd_reg(2'd2, d); check("R6 ctrl untouched", d, 8'h00);
   endtask

   task automatic t_enable();
      int hi;
      wr_reg(2'd2, 8'h02);
      @(negedge clk); nl = 1; estd = 1;
      hi = 0;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk); if (irq) hi++;
         if (i == 0) begin nl = 0; estd = 0; end
      end
      check("R7 disabled groups no pulse", 8'(hi), 8'd0);
      @(negedge clk); drdy = 1;
      hi = 0;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk); if (irq) hi++;
         if (i == 0) drdy = 0;
      end
      check("R7 enabled group pulses", 8'(hi), 8'(PW));
      wr_reg(2'd2, 8'h00);
      flush();
   endtask

   task automatic t_single();
      logic [11:0] got, exp;
      wr_reg(2'd2, 8'h04);
      @(negedge clk); estd = 1;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk); got[i] = irq;
         if (i == 0) estd = 0;
         if (i == 1) eaux = 1;
      end
      exp = 12'((1 << PW) - 1);
      check("R8 single pulse pattern lo", got[7:0], exp[7:0]);
      check("R8 single pulse pattern hi", {4'd0, got[11:8]}, {4'd0, exp[11:8]});
      wr_reg(2'd2, 8'h00);
      flush();
   endtask

   task automatic t_repeat();
      logic [15:0] got, exp;
      logic [7:0] d;
      int hi;
      wr_reg(2'd2, 8'h03);
      @(negedge clk); drdy = 1;
      for (int i = 0; i < 16; i++) begin
         @(negedge clk); got[i] = irq;
         exp[i] = (i % PP) < PW;
         if (i == 0) drdy = 0;
      end
      check("R9 train lo", got[7:0], exp[7:0]);
      check("R9 train hi", got[15:8], exp[15:8]);
      rd_reg(2'd3, d);
      check("R9 stop read data", d, 8'h01);
      hi = irq ? 1 : 0;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk); if (irq) hi++;
      end
      check("R9 stopped after read", 8'(hi), 8'd0);
      wr_reg(2'd2, 8'h00);
      flush();
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_flag_bits();
      t_clear_hold();
      t_collision();
      t_live();
      t_ctrl();
      t_enable();
      t_single();
      t_repeat();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule